// File: doc/BRIEF.md
# Tag-Stripping Address Generator with Region Type Trap

This block produces the effective address for tagged load and store instructions on pointers that carry a type tag in their top bits. An instruction provides a base register value, a 12-bit signed displacement and a 4-bit tag constant. Together these fill the usual 16-bit immediate field. The unit first adds the sign-extended displacement to the base. It then XORs the tag constant into the top four address bits. If the pointer's real tag equals the tag named by the instruction, the two cancel and the access lands in a mapped region. If the tags differ, the top bits land on a pattern that software leaves unmapped.

A small programmable table decides which values of the top four address bits are mapped. Each entry holds a prefix and an enable bit. An access whose top bits match no enabled entry raises a type trap. A word access with either low address bit set raises a separate alignment trap. A trap blocks the memory strobe for that access. It also records the faulting address and the instruction's tag, so a handler can XOR the tag back in and recover the pointer it started from. Results appear one clock after the request.

Top module: `tagAddrUnit`

## Requirements
- R1: The effective address is `(base + signExtend(offset)) XOR (tag << 28)`, computed modulo 2^32. The add comes first, so a carry out of bit 27 of the sum moves into the tag field before the XOR is applied.
- R2: A load and a store with the same operands produce the same address. `memIsStore` repeats the `reqIsStore` value of the access.
- R3: An accepted access raises `memValid` for exactly one cycle, in the cycle after `reqValid`, and carries the effective address on `memAddr`. An access is accepted when address bits [31:28] equal the prefix of at least one enabled region entry and it is not misaligned.
- R4: If no enabled entry matches bits [31:28], `typeTrap` is high for one cycle in the cycle after the request, and `memValid` stays low for that access.
- R5: When a trap fires, `trapAddr` takes the faulting effective address and `trapTag` takes the instruction's tag, in the same cycle as the trap. Both hold their values until the next trap. `trapAddr XOR (trapTag << 28)` equals base plus the sign-extended offset.
- R6: A word access (`reqIsWord` = 1) whose effective address has bits [1:0] not equal to zero raises `alignTrap` in the cycle after the request, with no memory strobe. A byte access (`reqIsWord` = 0) never raises the alignment trap. A single access can raise both traps.
- R7: A write to the region table (`cfgWrEn` with index, prefix and enable) applies to requests in later cycles. Clearing an entry's enable makes accesses to its prefix raise the type trap.
- R8: After reset every output is zero and every region entry is disabled, so the first access with no configuration raises the type trap.
- R9: In a cycle after one with `reqValid` low, `memValid`, `typeTrap` and `alignTrap` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | An access is presented this cycle |
| reqIsStore | input | 1 | 1 = store, 0 = load |
| reqIsWord | input | 1 | 1 = word access, checked for alignment |
| reqBase | input | 32 | Base register value |
| reqOffset | input | 12 | Signed displacement from the immediate field |
| reqTag | input | 4 | Tag constant from the immediate field |
| cfgWrEn | input | 1 | Writes one region table entry |
| cfgIdx | input | 2 | Index of the region entry to write |
| cfgPrefix | input | 4 | Value of address bits [31:28] that the entry maps |
| cfgEnable | input | 1 | Enable bit of the entry |
| memValid | output | 1 | Memory request strobe |
| memIsStore | output | 1 | Direction of the memory request |
| memAddr | output | 32 | Effective address of the memory request |
| typeTrap | output | 1 | The address falls outside every enabled region |
| alignTrap | output | 1 | Misaligned word access |
| trapAddr | output | 32 | Effective address of the most recent trapping access |
| trapTag | output | 4 | Tag of the most recent trapping access |

## Verification
A wrong region table entry shows up in the cycle after the next access to that prefix: a strobe appears where a trap was due, or the reverse. An error in the add-then-XOR order or in the sign extension shows up on `memAddr` or `trapAddr` in the cycle after the access. Carry-into-tag and negative-displacement cases are exercised so that these errors are visible. A trap record that is overwritten or lost stays wrong at the ports until the next trap, so every idle cycle also compares the held `trapAddr` and `trapTag` values.

// File: rtl/tagAddrPkg.sv
package tagAddrPkg;

  // Strobes sent by the control module to the datapath for one access
  typedef struct packed {
    logic issueMem;   // launch a memory request
    logic trapType;   // region mismatch trap
    logic trapAlign;  // misaligned word trap
  } ctrlStrobes_t;

endpackage

// File: rtl/tagAddrControl.sv
module tagAddrControl
  import tagAddrPkg::*;
(
  input  logic         reqValid,
  input  logic         regionHit,
  input  logic         misaligned,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    if (reqValid) begin
      strobes.trapType  = !regionHit;
      strobes.trapAlign = misaligned;
      strobes.issueMem  = regionHit && !misaligned;
    end
  end

endmodule

// File: rtl/tagAddrDatapath.sv
module tagAddrDatapath
  import tagAddrPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int TAG_W       = 4,
  parameter int OFF_W       = 12,
  parameter int NUM_REGIONS = 4,
  localparam int DATUM_LEN  = ADDR_W - TAG_W,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqIsStore,
  input  logic              reqIsWord,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [TAG_W-1:0]  cfgPrefix,
  input  logic              cfgEnable,
  input  ctrlStrobes_t      strobes,
  output logic              regionHit,
  output logic              misaligned,
  output logic              memValid,
  output logic              memIsStore,
  output logic [ADDR_W-1:0] memAddr,
  output logic              typeTrap,
  output logic              alignTrap,
  output logic [ADDR_W-1:0] trapAddr,
  output logic [TAG_W-1:0]  trapTag
);

  logic [ADDR_W-1:0] offsetExt;
  logic [ADDR_W-1:0] sumAddr;
  logic [ADDR_W-1:0] effAddr;
  logic [TAG_W-1:0]  highBits;

  assign offsetExt = {{(ADDR_W-OFF_W){reqOffset[OFF_W-1]}}, reqOffset};
  assign sumAddr   = reqBase + offsetExt;
  assign effAddr   = sumAddr ^ {reqTag, {DATUM_LEN{1'b0}}};
  assign highBits  = effAddr[ADDR_W-1 -: TAG_W];
  assign misaligned = reqIsWord && (effAddr[1:0] != 2'b00);

  // Region table
  logic [TAG_W-1:0]       regPrefix [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] regEnable;
  logic [NUM_REGIONS-1:0] matchVec;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGIONS; gi++) begin : g_region
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          regPrefix[gi] <= '0;
          regEnable[gi] <= 1'b0;
        end else if (cfgWrEn && (cfgIdx == IDX_W'(gi))) begin
          regPrefix[gi] <= cfgPrefix;
          regEnable[gi] <= cfgEnable;
        end
      end
      assign matchVec[gi] = regEnable[gi] && (regPrefix[gi] == highBits);
    end
  endgenerate

  assign regionHit = |matchVec;

  // Registered results
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      memValid   <= 1'b0;
      memIsStore <= 1'b0;
      memAddr    <= '0;
      typeTrap   <= 1'b0;
      alignTrap  <= 1'b0;
      trapAddr   <= '0;
      trapTag    <= '0;
    end else begin
      memValid  <= strobes.issueMem;
      typeTrap  <= strobes.trapType;
      alignTrap <= strobes.trapAlign;
      if (strobes.issueMem) begin
        memAddr    <= effAddr;
        memIsStore <= reqIsStore;
      end
      if (strobes.trapType || strobes.trapAlign) begin
        trapAddr <= effAddr;
        trapTag  <= reqTag;
      end
    end
  end

endmodule

// File: rtl/tagAddrUnit.sv
module tagAddrUnit
  import tagAddrPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int TAG_W       = 4,
  parameter int OFF_W       = 12,
  parameter int NUM_REGIONS = 4,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqIsStore,
  input  logic              reqIsWord,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [TAG_W-1:0]  cfgPrefix,
  input  logic              cfgEnable,
  output logic              memValid,
  output logic              memIsStore,
  output logic [ADDR_W-1:0] memAddr,
  output logic              typeTrap,
  output logic              alignTrap,
  output logic [ADDR_W-1:0] trapAddr,
  output logic [TAG_W-1:0]  trapTag
);

  ctrlStrobes_t strobes;
  logic         regionHit;
  logic         misaligned;

  tagAddrControl ctrl_i (
    .reqValid  (reqValid),
    .regionHit (regionHit),
    .misaligned(misaligned),
    .strobes   (strobes)
  );

  tagAddrDatapath #(
    .ADDR_W     (ADDR_W),
    .TAG_W      (TAG_W),
    .OFF_W      (OFF_W),
    .NUM_REGIONS(NUM_REGIONS)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqIsStore(reqIsStore),
    .reqIsWord (reqIsWord),
    .reqBase   (reqBase),
    .reqOffset (reqOffset),
    .reqTag    (reqTag),
    .cfgWrEn   (cfgWrEn),
    .cfgIdx    (cfgIdx),
    .cfgPrefix (cfgPrefix),
    .cfgEnable (cfgEnable),
    .strobes   (strobes),
    .regionHit (regionHit),
    .misaligned(misaligned),
    .memValid  (memValid),
    .memIsStore(memIsStore),
    .memAddr   (memAddr),
    .typeTrap  (typeTrap),
    .alignTrap (alignTrap),
    .trapAddr  (trapAddr),
    .trapTag   (trapTag)
  );

endmodule

// File: rtl/tagAddrChecker.sv
module tagAddrChecker #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              memValid,
  input logic              typeTrap,
  input logic              alignTrap,
  input logic [ADDR_W-1:0] trapAddr,
  input logic [TAG_W-1:0]  trapTag
);

  AST_TRAP_BLOCKS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (typeTrap || alignTrap) |-> !memValid); // R4

  AST_MEM_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    memValid |-> $past(reqValid)); // R9

  AST_TRAP_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (typeTrap || alignTrap) |-> $past(reqValid)); // R9

  AST_TRAP_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!typeTrap && !alignTrap) |-> ($stable(trapAddr) && $stable(trapTag))); // R5

  AST_ALIGN_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    alignTrap |-> (trapAddr[1:0] != 2'b00)); // R6

endmodule

bind tagAddrUnit tagAddrChecker #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .reqValid (reqValid),
  .memValid (memValid),
  .typeTrap (typeTrap),
  .alignTrap(alignTrap),
  .trapAddr (trapAddr),
  .trapTag  (trapTag)
);

// File: tb/tagAddrUnit_tb_top.sv
module tagAddrUnit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0, reqIsStore = 1'b0, reqIsWord = 1'b0;
  logic [31:0] reqBase = '0;
  logic [11:0] reqOffset = '0;
  logic [3:0]  reqTag = '0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgIdx = '0;
  logic [3:0]  cfgPrefix = '0;
  logic        cfgEnable = 1'b0;
  logic        memValid, memIsStore, typeTrap, alignTrap;
  logic [31:0] memAddr, trapAddr;
  logic [3:0]  trapTag;

  always #2 clk = ~clk;   // 250 MHz

  tagAddrUnit dut_i (.*);

  typedef struct {
    logic        mv;
    logic        st;
    logic [31:0] ma;
    logic        tt;
    logic        at;
    logic [31:0] ta;
    logic [3:0]  tg;
    string       req;
  } expItem_t;

  expItem_t   expQ[$];
  int         errors = 0;
  int         checks = 0;
  bit         monitorOn = 1'b0;
  logic [3:0] mPrefix [4];
  logic       mEnable [4];
  logic [31:0] heldAddr = '0;
  logic [3:0]  heldTag = '0;
  logic        lastMemStore = 1'b0;
  logic [31:0] lastMemAddr = '0;

  function automatic logic [31:0] calcEa(logic [31:0] b, logic [11:0] o, logic [3:0] t);
    return (b + {{20{o[11]}}, o}) ^ {t, 28'h0};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: presents one access and pushes what the ports must show next cycle
  task automatic doReq(string req, logic [31:0] b, logic [11:0] o, logic [3:0] t,
                       logic st, logic wd);
    expItem_t e;
    logic [31:0] ea;
    logic hit;
    @(negedge clk);
    ea = calcEa(b, o, t);
    hit = 1'b0;
    for (int i = 0; i < 4; i++) if (mEnable[i] && mPrefix[i] == ea[31:28]) hit = 1'b1;
    e.req = req;
    e.tt = !hit;
    e.at = wd && (ea[1:0] != 2'b00);
    e.mv = !e.tt && !e.at;
    if (e.mv) begin lastMemAddr = ea; lastMemStore = st; end
    if (e.tt || e.at) begin heldAddr = ea; heldTag = t; end
    e.ma = lastMemAddr; e.st = lastMemStore; e.ta = heldAddr; e.tg = heldTag;
    expQ.push_back(e);
    reqValid = 1'b1; reqBase = b; reqOffset = o; reqTag = t;
    reqIsStore = st; reqIsWord = wd;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0; cfgWrEn = 1'b0;
    end
  endtask

  task automatic cfgWrite(logic [1:0] idx, logic [3:0] p, logic en);
    @(negedge clk);
    reqValid = 1'b0;
    cfgWrEn = 1'b1; cfgIdx = idx; cfgPrefix = p; cfgEnable = en;
    mPrefix[idx] = p; mEnable[idx] = en;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // Monitor: compares each result one edge after the request
  always @(posedge clk) begin
    #1;
    if (monitorOn) begin
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check(e.req, "memValid", 32'(memValid), 32'(e.mv));
        check(e.req, "typeTrap", 32'(typeTrap), 32'(e.tt));
        check(e.req, "alignTrap", 32'(alignTrap), 32'(e.at));
        if (e.mv) begin
          check(e.req, "memAddr", memAddr, e.ma);
          check(e.req, "memIsStore", 32'(memIsStore), 32'(e.st));
        end
        check(e.req, "trapAddr", trapAddr, e.ta);
        check(e.req, "trapTag", 32'(trapTag), 32'(e.tg));
      end else begin
        check("R9", "idle strobes", {29'h0, memValid, typeTrap, alignTrap}, 32'h0);
        check("R5", "held trapAddr", trapAddr, heldAddr);
        check("R5", "held trapTag", 32'(trapTag), 32'(heldTag));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mPrefix[i] = '0; mEnable[i] = 1'b0; end
    repeat (3) @(negedge clk);
    // R8: reset values at the ports
    check("R8", "outputs in reset",
          {27'h0, memValid, memIsStore, typeTrap, alignTrap, 1'b0} | memAddr | trapAddr | 32'(trapTag),
          32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "outputs after reset",
          {28'h0, memValid, memIsStore, typeTrap, alignTrap} | memAddr | trapAddr, 32'h0);
    monitorOn = 1'b1;
    // R8: table empty, every access traps
    doReq("R8", 32'h2000_0100, 12'h004, 4'h0, 1'b0, 1'b1);
    idle(2);
    cfgWrite(2'd0, 4'h2, 1'b1);
    cfgWrite(2'd1, 4'h5, 1'b1);
    idle(1);
    // R3/R1: untagged access in region 2
    doReq("R3", 32'h2000_1000, 12'h010, 4'h0, 1'b0, 1'b1);
    // R1: tagged pointer (top 7) with tag 5 -> top 2
    doReq("R1", 32'h7000_2000, 12'h008, 4'h5, 1'b0, 1'b1);
    // R2: same operands as a store
    doReq("R2", 32'h7000_2000, 12'h008, 4'h5, 1'b1, 1'b1);
    idle(1);
    // R4/R5: wrong tag -> top 4, trap; handler recovers 0x70002008
    doReq("R4", 32'h7000_2000, 12'h008, 4'h3, 1'b0, 1'b1);
    idle(1);
    @(negedge clk);
    check("R5", "recovered pointer", trapAddr ^ {trapTag, 28'h0}, 32'h7000_2008);
    // R1: negative offset
    doReq("R1", 32'h2000_0010, 12'hFF0, 4'h0, 1'b0, 1'b1);
    // R1: carry into tag field before XOR: 0x2FFFFFF8+0x10 = 0x30000008
    doReq("R1", 32'h2FFF_FFF8, 12'h010, 4'h0, 1'b0, 1'b1);
    doReq("R1", 32'h2FFF_FFF8, 12'h010, 4'h1, 1'b1, 1'b1);
    idle(1);
    // R6: misaligned word traps, same byte access passes
    doReq("R6", 32'h2000_0000, 12'h002, 4'h0, 1'b0, 1'b1);
    doReq("R6", 32'h2000_0000, 12'h002, 4'h0, 1'b0, 1'b0);
    // R6: both traps at once
    doReq("R6", 32'h9000_0001, 12'h000, 4'h0, 1'b1, 1'b1);
    idle(1);
    // R7: region 5 works, then is disabled and traps
    doReq("R7", 32'h5000_0040, 12'h000, 4'h0, 1'b1, 1'b1);
    idle(1);
    cfgWrite(2'd1, 4'h5, 1'b0);
    doReq("R7", 32'h5000_0040, 12'h000, 4'h0, 1'b1, 1'b1);
    // R7: new prefix in slot 3
    cfgWrite(2'd3, 4'hA, 1'b1);
    doReq("R7", 32'hA000_0080, 12'h7FC, 4'h0, 1'b0, 1'b1);
    idle(3);
    monitorOn = 1'b0;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule